// File: doc/BRIEF.md
# Write-Masked Control Register Pair

This block holds a 64-bit control register and a 64-bit lock mask that sits beside it. Each set bit of the lock mask freezes the control bit at the same position. A control write can use either of two equivalent targets, the main target and an alias target. The lock applies to both, so a locked bit cannot be changed through either one. Only a fixed set of bit positions exists in either register. Every other position reads as zero and discards written data.

The mask has a protection rule of its own. At the lowest privileged level, a mask write is accepted only while the mask is all zero. Once any lock bit is set, that level cannot loosen or change the mask, and the attempt is refused. The two higher privilege levels may rewrite the mask at any time. Any write from the unprivileged level is refused. A refusal raises a one-cycle "undefined" flag in the same cycle as the request, and neither register changes.

Top module: `wmask_ctrl_pair`

## Requirements
- R1: In the cycle after a cycle with `rst` high, `ctrl_q` and `mask_q` are zero, and `undef_o` is low while no write is requested.
- R2: A write with `wr_sel`=0 (main control target) from `wr_priv` 1, 2 or 3 loads `wr_data` into every implemented control bit whose lock bit is 0. The new value is visible one cycle later.
- R3: A write with `wr_sel`=1 (alias control target) has exactly the same effect as a write to the main control target.
- R4: A control bit whose lock bit in `mask_q` is 1 keeps its value on any control write. A control bit whose lock bit is 0 takes the new data.
- R5: Only bit positions 21, 20, 18, 17, 16, 15, 14, 11, 10 and 5 down to 0 are implemented (mask 0x37CC3F). All other bits of `ctrl_q` and `mask_q` always read 0, and writes to them have no effect.
- R6: A mask write (`wr_sel`=2) from `wr_priv`=1 while `mask_q` is zero loads the implemented bits of `wr_data` into `mask_q`.
- R7: A mask write from `wr_priv`=1 while `mask_q` is nonzero is refused. `undef_o` is high in that cycle, and `mask_q` is unchanged.
- R8: A mask write from `wr_priv`=2 or 3 always loads the implemented bits of `wr_data`, whatever the current mask, and `undef_o` stays low.
- R9: Any write from `wr_priv`=0 to targets 0, 1 or 2 is refused. `undef_o` is high in that cycle, and neither register changes.
- R10: `undef_o` is combinational from the current request and mask. It is low whenever `wr_en` is low or `wr_sel`=3. Select code 3 names no target, and a write to it changes nothing.
- R11: With `wr_en` low, neither register changes, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request strobe |
| wr_sel | input | 2 | Target: 0 control, 1 control alias, 2 lock mask, 3 none |
| wr_priv | input | 2 | Requesting level: 0 unprivileged, 1 lowest privileged, 2 and 3 higher |
| wr_data | input | 64 | Write data |
| ctrl_q | output | 64 | Control register value |
| mask_q | output | 64 | Lock mask value |
| undef_o | output | 1 | Refusal flag, high in the cycle of a refused write |

## Verification
The hardest case to reach is a refused mask write from the lowest privileged level. A refusal needs a nonzero mask first, and that level can only set the mask from zero. After that, only a higher level can change the mask again. Directed sequences set the mask from level 1 and then try to rewrite it. They also clear the mask from level 3 and show that level 1 regains write access. Random traffic weights level 1 heavily against occasional clears from higher levels, so the mask keeps moving between the locked and unlocked states. Partially locked masks are also checked against alternating data through both control targets.

// File: rtl/wmcr_pkg.sv
package wmcr_pkg;
  localparam int unsigned REG_W = 64;

  // write target codes
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_ALIAS = 2'd1;
  localparam logic [1:0] SEL_MASK  = 2'd2;
  localparam logic [1:0] SEL_NONE  = 2'd3;

  // requesting level codes
  localparam logic [1:0] LVL_USER = 2'd0;
  localparam logic [1:0] LVL_KERN = 2'd1;
  localparam logic [1:0] LVL_HYP  = 2'd2;
  localparam logic [1:0] LVL_MON  = 2'd3;

  // positions that exist in both registers
  localparam logic [REG_W-1:0] IMPL_DEFAULT = 64'h0000_0000_0037_CC3F;

  typedef struct packed {
    logic ctrl_we;
    logic mask_we;
    logic refuse;
  } wr_decision_t;
endpackage

// File: rtl/wmcr_access_check.sv
module wmcr_access_check
  import wmcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [1:0] wr_priv,
  input  logic       mask_nonzero,
  output wr_decision_t dec
);
  logic is_user;
  logic to_ctrl;
  logic to_mask;
  logic mask_locked_out;

  always_comb begin
    is_user         = (wr_priv == LVL_USER);
    to_ctrl         = (wr_sel == SEL_CTRL) || (wr_sel == SEL_ALIAS);
    to_mask         = (wr_sel == SEL_MASK);
    mask_locked_out = to_mask && (wr_priv == LVL_KERN) && mask_nonzero;
    dec.ctrl_we = wr_en && to_ctrl && !is_user;
    dec.mask_we = wr_en && to_mask && !is_user && !mask_locked_out;
    dec.refuse  = wr_en && (to_ctrl || to_mask) && (is_user || mask_locked_out);
  end

  // R9
  user_refused_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_priv == LVL_USER && wr_sel != SEL_NONE) |-> (dec.refuse && !dec.ctrl_we && !dec.mask_we));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || wr_sel == SEL_NONE) |-> (!dec.refuse && !dec.ctrl_we && !dec.mask_we));

  // R8
  high_level_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_MASK && wr_priv[1]) |-> (dec.mask_we && !dec.refuse));
endmodule

// File: rtl/wmcr_mask_reg.sv
module wmcr_mask_reg
  import wmcr_pkg::*;
#(
  parameter int unsigned W = REG_W,
  parameter logic [W-1:0] IMPL = IMPL_DEFAULT[W-1:0]
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic         refuse,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic         nonzero
);
  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      assign nxt[i] = we ? wdata[i] : q[i];
    end else begin : g_rsvd
      assign nxt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign nonzero = |q;

  // R5
  mask_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (q & ~IMPL) == '0);

  // R7
  mask_refused_hold_chk: assert property (@(posedge clk) disable iff (rst)
    refuse |=> $stable(q));

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == ($past(wdata) & IMPL)));
endmodule

// File: rtl/wmcr_ctrl_reg.sv
module wmcr_ctrl_reg
  import wmcr_pkg::*;
#(
  parameter int unsigned W = REG_W,
  parameter logic [W-1:0] IMPL = IMPL_DEFAULT[W-1:0]
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] lock,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      assign nxt[i] = (we && !lock[i]) ? wdata[i] : q[i];
    end else begin : g_rsvd
      assign nxt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R4
  locked_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & $past(lock)) == ($past(q) & $past(lock))));

  // R5
  ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (q & ~IMPL) == '0);

  // R11
  ctrl_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/wmask_ctrl_pair.sv
module wmask_ctrl_pair
  import wmcr_pkg::*;
#(
  parameter int unsigned W = REG_W,
  parameter logic [W-1:0] IMPL = IMPL_DEFAULT[W-1:0]
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [1:0]   wr_priv,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ctrl_q,
  output logic [W-1:0] mask_q,
  output logic         undef_o
);
  wr_decision_t dec;
  logic         mask_nz;

  wmcr_access_check u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_priv      (wr_priv),
    .mask_nonzero (mask_nz),
    .dec          (dec)
  );

  wmcr_mask_reg #(.W(W), .IMPL(IMPL)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .we      (dec.mask_we),
    .refuse  (dec.refuse),
    .wdata   (wr_data),
    .q       (mask_q),
    .nonzero (mask_nz)
  );

  wmcr_ctrl_reg #(.W(W), .IMPL(IMPL)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .we    (dec.ctrl_we),
    .lock  (mask_q),
    .wdata (wr_data),
    .q     (ctrl_q)
  );

  assign undef_o = dec.refuse;

  // R7
  kern_locked_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_MASK && wr_priv == LVL_KERN && mask_q != '0) |-> undef_o);

  // R9
  refuse_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    undef_o |=> ($stable(ctrl_q) && $stable(mask_q)));
endmodule

// File: tb/wmask_ctrl_pair_tb.sv
module wmask_ctrl_pair_tb;
  localparam logic [63:0] IMPL = 64'h0000_0000_0037_CC3F;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [1:0]  wr_priv;
  logic [63:0] wr_data;
  logic [63:0] ctrl_q;
  logic [63:0] mask_q;
  logic        undef_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [63:0] m_ctrl = '0;
  logic [63:0] m_mask = '0;

  always #10 clk = ~clk;

  wmask_ctrl_pair u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_priv(wr_priv),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .mask_q(mask_q), .undef_o(undef_o)
  );

  function automatic logic exp_refuse(logic en, logic [1:0] sel, logic [1:0] lvl, logic [63:0] mk);
    if (!en || sel == 2'd3) return 1'b0;
    if (lvl == 2'd0) return 1'b1;
    return (sel == 2'd2) && (lvl == 2'd1) && (mk != '0);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic op(logic en, logic [1:0] sel, logic [1:0] lvl, logic [63:0] d, string req);
    logic r;
    wr_en = en; wr_sel = sel; wr_priv = lvl; wr_data = d;
    #2;
    r = exp_refuse(en, sel, lvl, m_mask);
    check({req, " undef"}, {63'd0, undef_o}, {63'd0, r});
    @(posedge clk);
    if (en && !r) begin
      if (sel == 2'd0 || sel == 2'd1)
        m_ctrl = (m_ctrl & m_mask) | (d & ~m_mask & IMPL);
      else if (sel == 2'd2)
        m_mask = d & IMPL;
    end
    @(negedge clk);
    wr_en = 1'b0;
    check({req, " ctrl"}, ctrl_q, m_ctrl);
    check({req, " mask"}, mask_q, m_mask);
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7193));
    rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_priv = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 ctrl", ctrl_q, '0);
    check("R1 mask", mask_q, '0);
    check("R1 undef", {63'd0, undef_o}, '0);

    op(1, 2'd0, 2'd1, '1, "R2 R5");
    op(1, 2'd1, 2'd2, 64'h0, "R3");
    op(1, 2'd1, 2'd3, 64'hA5A5_A5A5_A5A5_A5A5, "R3 R5");
    op(0, 2'd0, 2'd1, 64'h5A5A, "R11");
    op(1, 2'd3, 2'd3, '1, "R10");
    op(1, 2'd0, 2'd0, '1, "R9");
    op(1, 2'd2, 2'd0, '1, "R9");
    op(1, 2'd2, 2'd1, 64'hFFFF_0000_0000_C00F, "R6 R5");
    op(1, 2'd0, 2'd1, '0, "R4");
    op(1, 2'd1, 2'd1, '1, "R4 R3");
    op(1, 2'd2, 2'd1, '0, "R7");
    op(1, 2'd2, 2'd1, '1, "R7");
    op(1, 2'd2, 2'd2, 64'h30_0000, "R8");
    op(1, 2'd0, 2'd1, 64'h0, "R4");
    op(1, 2'd2, 2'd3, '0, "R8");
    op(1, 2'd2, 2'd1, 64'h1, "R6");

    for (int i = 0; i < 400; i++) begin
      logic [1:0]  s, l;
      logic [63:0] d;
      logic        e;
      int          pick;
      e    = ($urandom % 8) != 0;
      s    = 2'($urandom);
      pick = $urandom % 10;
      l    = (pick < 6) ? 2'd1 : (pick < 8) ? 2'd0 : 2'($urandom % 2 + 2);
      d    = {$urandom, $urandom};
      if (($urandom % 4) == 0) d = d & {$urandom, $urandom};
      op(e, s, l, d, "R2 R4 R6 R7 R8 rand");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule